// File: doc/BRIEF.md
# Programmable Loop Divider and Phase Comparator

This block is the digital core of a frequency synthesizer loop. The oscillator's edges arrive as one-cycle clock-enable ticks on one of two band inputs. Each band has its own fixed prescaler: divide by 8 on the low band and divide by 64 on the high band. The high-band figure is the base ratio of a dual-modulus prescaler. A band select input chooses which prescaled stream feeds a programmable down-counter. That counter produces one output pulse for every N+1 prescaled pulses, where N is a 13-bit code. A new code is taken up only when the counter reaches its terminal count, so no period is ever cut short or stretched by a code change.

The divided feedback pulse and a reference pulse feed a two-flip-flop phase-frequency detector.
- A reference pulse that arrives first raises pump-up, which sources current into the loop filter.
- A feedback pulse that arrives first raises pump-down, which sinks current.
- The second event clears both flip-flops.

A pump-enable input gates the pump controls. When it is low, the pump output is forced to the high-impedance state. The detector keeps its state while disabled.

Top module: `synth_loop_core`

## Requirements
- R1: After reset, div_out, pump_up, pump_dn and pump_oe are all 0.
- R2: With band_fm=0, every 8 am_tick cycles make one prescaled pulse. With code N=0 each prescaled pulse gives one div_out pulse.
- R3: With band_fm=1, every 64 fm_tick cycles make one prescaled pulse.
- R4: After reset, the first prescaled pulse gives a div_out pulse and loads the code. With code N held, P prescaled pulses give ceil(P/(N+1)) div_out pulses. Each div_out pulse lasts one cycle.
- R5: A change of div_code only takes effect at the next terminal count. The period in progress finishes with the old code.
- R6: A reference pulse with no pending feedback sets pump_up=1. It stays set until a div_out pulse clears it.
- R7: A div_out pulse with no pending reference sets pump_dn=1. It stays set until a reference pulse clears it.
- R8: pump_up and pump_dn are never 1 together. A reference pulse in the same cycle as div_out leaves both at 0.
- R9: While pump_en=0, pump_up, pump_dn and pump_oe are 0. The detector state is kept and reappears when pump_en returns to 1.
- R10: Code N=0 divides by one, so every prescaled pulse gives a div_out pulse.
- R11: Ticks on the band not selected by band_fm do not produce div_out pulses.
- R12: pump_oe=1 exactly when pump_en=1 and one of pump_up or pump_dn is 1. Otherwise the pump is in the high-impedance state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| am_tick | input | 1 | Low-band oscillator edge enable |
| fm_tick | input | 1 | High-band oscillator edge enable |
| band_fm | input | 1 | Band select: 1 selects the high band, 0 selects the low band |
| div_code | input | 13 | Divide code N (ratio N+1) |
| ref_pulse | input | 1 | Reference edge, one cycle |
| pump_en | input | 1 | Pump enable; low forces the high-impedance state |
| div_out | output | 1 | Divided feedback pulse |
| pump_up | output | 1 | Pump source control |
| pump_dn | output | 1 | Pump sink control |
| pump_oe | output | 1 | Pump drive enable (0 means high impedance) |

## Verification
The bench changes the code in the middle of a period. A design that reloads at once would give a different count of divided pulses than the expected 2 and then 5. It uses N=0, where a counter that divides by N instead of N+1 would give no pulses or twice as many. It drives ticks on the deselected band, which a design with a wrong band select would count. It lines up a reference pulse exactly with the divided pulse, where a detector that does not clear on coincidence would leave a pump line asserted. It also drops pump_en while pump-up is pending. A design that clears the detector on disable, instead of only masking the outputs, would lose the correction once pump_en returns to 1.

// File: rtl/synth_pkg.sv
package synth_pkg;
   typedef enum logic {BAND_AM = 1'b0, BAND_FM = 1'b1} band_e;
   localparam int NUM_BANDS = 2;
endpackage

// File: rtl/synth_prescale.sv
module synth_prescale #(
   parameter int RATIO = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   output logic pulse_o
);
   localparam int CW = (RATIO > 1) ? $clog2(RATIO) : 1;
   localparam logic [CW-1:0] LAST = CW'(RATIO - 1);

   logic [CW-1:0] cnt_q;
   logic          pulse_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         pulse_q <= 1'b0;
      end else begin
         pulse_q <= tick_i && (cnt_q == LAST);
         if (tick_i) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      end
   end

   assign pulse_o = pulse_q;
endmodule

// File: rtl/synth_prog_div.sv
module synth_prog_div #(
   parameter int CODE_W = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step_i,
   input  logic [CODE_W-1:0] code_i,
   output logic              tc_o
);
   logic [CODE_W-1:0] cnt_q;
   logic              tc_q;
   logic              at_end;

   assign at_end = (cnt_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         tc_q  <= 1'b0;
      end else begin
         tc_q <= step_i && at_end;
         if (step_i) cnt_q <= at_end ? code_i : cnt_q - 1'b1;
      end
   end

   assign tc_o = tc_q;
endmodule

// File: rtl/synth_pfd.sv
module synth_pfd (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_i,
   input  logic fb_i,
   output logic up_o,
   output logic dn_o
);
   logic up_q, dn_q;
   logic nxt_up, nxt_dn, clr;

   always_comb begin
      nxt_up = up_q | ref_i;
      nxt_dn = dn_q | fb_i;
      clr    = nxt_up & nxt_dn;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         up_q <= 1'b0;
         dn_q <= 1'b0;
      end else begin
         up_q <= nxt_up & ~clr;
         dn_q <= nxt_dn & ~clr;
      end
   end

   assign up_o = up_q;
   assign dn_o = dn_q;
endmodule

// File: rtl/synth_loop_core.sv
module synth_loop_core
   import synth_pkg::*;
#(
   parameter int CODE_W = 13,
   parameter int AM_PRE = 8,
   parameter int FM_PRE = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              am_tick,
   input  logic              fm_tick,
   input  logic              band_fm,
   input  logic [CODE_W-1:0] div_code,
   input  logic              ref_pulse,
   input  logic              pump_en,
   output logic              div_out,
   output logic              pump_up,
   output logic              pump_dn,
   output logic              pump_oe
);
   if (CODE_W < 1) begin : g_bad_code_w
      $error("CODE_W must be at least 1");
   end
   if (AM_PRE < 2 || FM_PRE < 2) begin : g_bad_pre
      $error("prescale ratios must be at least 2");
   end

   logic [NUM_BANDS-1:0] raw_tick;
   logic [NUM_BANDS-1:0] pre;
   logic                 step;
   logic                 up_s, dn_s;
   band_e                band_sel;

   assign raw_tick = {fm_tick, am_tick};

   for (genvar b = 0; b < NUM_BANDS; b++) begin : g_pre
      localparam int RATIO = (b == int'(BAND_AM)) ? AM_PRE : FM_PRE;
      synth_prescale #(.RATIO(RATIO)) u_pre (
         .clk     (clk),
         .rst_n   (rst_n),
         .tick_i  (raw_tick[b]),
         .pulse_o (pre[b])
      );
   end

   assign band_sel = band_e'(band_fm);
   assign step     = pre[band_sel];

   synth_prog_div #(.CODE_W(CODE_W)) u_div (
      .clk    (clk),
      .rst_n  (rst_n),
      .step_i (step),
      .code_i (div_code),
      .tc_o   (div_out)
   );

   synth_pfd u_pfd (
      .clk   (clk),
      .rst_n (rst_n),
      .ref_i (ref_pulse),
      .fb_i  (div_out),
      .up_o  (up_s),
      .dn_o  (dn_s)
   );

   assign pump_up = up_s & pump_en;
   assign pump_dn = dn_s & pump_en;
   assign pump_oe = pump_en & (up_s | dn_s);
endmodule

// File: rtl/synth_loop_chk.sv
module synth_loop_chk (
   input logic clk,
   input logic rst_n,
   input logic ref_pulse,
   input logic pump_en,
   input logic div_out,
   input logic pump_up,
   input logic pump_dn,
   input logic pump_oe
);
   p_never_both_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(pump_up && pump_dn));

   p_div_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      div_out |=> !div_out);

   p_ref_sets_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_pulse && !div_out && pump_en && !pump_dn) |=> (pump_up || !pump_en));

   p_fb_sets_dn_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (div_out && !ref_pulse && pump_en && !pump_up) |=> (pump_dn || !pump_en));

   p_coincide_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (div_out && ref_pulse && pump_en && !pump_up && !pump_dn) |=> (!pump_up && !pump_dn));

   p_disabled_hiz_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !pump_en |-> (!pump_oe && !pump_up && !pump_dn));

   p_oe_drive_r12: assert property (@(posedge clk) disable iff (!rst_n)
      pump_oe |-> (pump_up || pump_dn));
endmodule

bind synth_loop_core synth_loop_chk chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .ref_pulse (ref_pulse),
   .pump_en   (pump_en),
   .div_out   (div_out),
   .pump_up   (pump_up),
   .pump_dn   (pump_dn),
   .pump_oe   (pump_oe)
);

// File: tb/synth_loop_core_tb.sv
`timescale 1ns/1ps
module synth_loop_core_tb_top;
   localparam int CODE_W = 13;
   localparam int AM_PRE = 8;
   localparam int FM_PRE = 64;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic am_tick = 1'b0, fm_tick = 1'b0, band_fm = 1'b0;
   logic [CODE_W-1:0] div_code = '0;
   logic ref_pulse = 1'b0, pump_en = 1'b1;
   logic div_out, pump_up, pump_dn, pump_oe;

   int checks = 0;
   int failures = 0;
   int div_total = 0;
   int base = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   synth_loop_core #(.CODE_W(CODE_W), .AM_PRE(AM_PRE), .FM_PRE(FM_PRE)) dut_i (
      .clk(clk), .rst_n(rst_n), .am_tick(am_tick), .fm_tick(fm_tick),
      .band_fm(band_fm), .div_code(div_code), .ref_pulse(ref_pulse),
      .pump_en(pump_en), .div_out(div_out), .pump_up(pump_up),
      .pump_dn(pump_dn), .pump_oe(pump_oe)
   );

   always @(negedge clk) if (rst_n && div_out) div_total++;

   function automatic int exp_div(int p, int n);
      return (p == 0) ? 0 : (p + n) / (n + 1);
   endfunction

   task automatic chk(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; am_tick = 0; fm_tick = 0; ref_pulse = 0; pump_en = 1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      base = div_total;
   endtask

   task automatic ticks(bit fm, int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (fm) fm_tick = 1'b1; else am_tick = 1'b1;
      end
      @(negedge clk);
      am_tick = 1'b0; fm_tick = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic ref_hit();
      @(negedge clk); ref_pulse = 1'b1;
      @(negedge clk); ref_pulse = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog all-requirements actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      do_reset();
      // R1 reset state
      chk(!div_out && !pump_up && !pump_dn && !pump_oe, "R1", {div_out,pump_up,pump_dn,pump_oe}, 0);

      // R2 / R10: low band, N=0, 20 ticks -> 2 pulses
      div_code = '0; band_fm = 1'b0;
      ticks(0, 20);
      chk(div_total - base == 2, "R2", div_total - base, 2);
      ticks(0, 4);
      chk(div_total - base == 3, "R10", div_total - base, 3);

      // R3: high band, N=0
      do_reset(); band_fm = 1'b1; div_code = '0;
      ticks(1, 63);
      chk(div_total - base == 0, "R3", div_total - base, 0);
      ticks(1, 1 + 2 * FM_PRE);
      chk(div_total - base == 3, "R3", div_total - base, 3);

      // R11: deselected band ticks ignored
      do_reset(); band_fm = 1'b0; div_code = '0;
      ticks(1, 3 * FM_PRE);
      chk(div_total - base == 0, "R11", div_total - base, 0);
      do_reset(); band_fm = 1'b1;
      ticks(0, 5 * AM_PRE);
      chk(div_total - base == 0, "R11", div_total - base, 0);

      // R4 random low band trials
      for (int t = 0; t < 8; t++) begin
         int n, p;
         n = int'($urandom_range(0, 15));
         p = int'($urandom_range(1, 30));
         do_reset(); band_fm = 1'b0; div_code = CODE_W'(n);
         ticks(0, p * AM_PRE);
         chk(div_total - base == exp_div(p, n), "R4", div_total - base, exp_div(p, n));
      end
      // R4 random high band trials
      for (int t = 0; t < 4; t++) begin
         int n, p;
         n = int'($urandom_range(0, 4));
         p = int'($urandom_range(1, 6));
         do_reset(); band_fm = 1'b1; div_code = CODE_W'(n);
         ticks(1, p * FM_PRE);
         chk(div_total - base == exp_div(p, n), "R4", div_total - base, exp_div(p, n));
      end
      // R4 large code: only the first pulse in 40 prescaled pulses
      do_reset(); band_fm = 1'b0; div_code = {CODE_W{1'b1}};
      ticks(0, 40 * AM_PRE);
      chk(div_total - base == 1, "R4", div_total - base, 1);

      // R5 code change mid-period
      do_reset(); band_fm = 1'b0; div_code = CODE_W'(3);
      ticks(0, AM_PRE);
      ticks(0, 2 * AM_PRE);
      div_code = '0;
      ticks(0, 2 * AM_PRE);
      chk(div_total - base == 2, "R5", div_total - base, 2);
      ticks(0, 3 * AM_PRE);
      chk(div_total - base == 5, "R5", div_total - base, 5);

      // R6 reference first
      do_reset(); band_fm = 1'b0; div_code = '0;
      ref_hit();
      chk(pump_up && !pump_dn, "R6", {pump_up,pump_dn}, 2);
      chk(pump_oe, "R12", pump_oe, 1);
      ticks(0, AM_PRE);
      chk(!pump_up && !pump_dn, "R6", {pump_up,pump_dn}, 0);
      chk(!pump_oe, "R12", pump_oe, 0);

      // R7 feedback first
      do_reset(); div_code = '0;
      ticks(0, AM_PRE);
      chk(!pump_up && pump_dn, "R7", {pump_up,pump_dn}, 1);
      ref_hit();
      chk(!pump_up && !pump_dn, "R7", {pump_up,pump_dn}, 0);

      // R8 coincident events
      do_reset(); div_code = '0;
      for (int i = 0; i < AM_PRE; i++) begin
         @(negedge clk); am_tick = 1'b1;
      end
      @(negedge clk); am_tick = 1'b0;
      for (int i = 0; i < 6 && !div_out; i++) @(negedge clk);
      ref_pulse = 1'b1;
      @(negedge clk); ref_pulse = 1'b0;
      @(negedge clk);
      chk(!pump_up && !pump_dn, "R8", {pump_up,pump_dn}, 0);
      chk(div_total - base == 1, "R8", div_total - base, 1);

      // R9 disable masks, state retained
      do_reset();
      ref_hit();
      pump_en = 1'b0;
      @(negedge clk);
      chk(!pump_up && !pump_dn && !pump_oe, "R9", {pump_up,pump_dn,pump_oe}, 0);
      repeat (3) @(negedge clk);
      pump_en = 1'b1;
      @(negedge clk);
      chk(pump_up && pump_oe, "R9", {pump_up,pump_oe}, 3);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule